// File: doc/BRIEF.md
# Host Command and Interrupt Event Unit

This unit is the host-facing control point of a DMA network controller. The host writes a 32-bit command word that starts or stops a DMA channel, acknowledges serviced events, requests a software interrupt, and switches interrupt delivery on or off. The transmit and receive engines raise events on a set of request strobes. The unit arbitrates those requests into a small ordered queue. The head of the queue is presented in a 16-bit interrupt word until the host acknowledges it.

The unit also guards one protocol rule. A transmit start issued while a transmit end-of-channel event is still outstanding is a host error. It is not forwarded. Instead, the unit queues an adapter-check event, and from then on it refuses every start command until reset.

Top module: `hci_unit`

## Requirements
- R1: After reset, irq_o, go_o and stop_o are 0, intr_o and cmd_o are zero, and interrupt delivery is disabled.
- R2: A command write with bit 31 set pulses go_o for one cycle, in the cycle after the write. A write with bit 30 set pulses stop_o the same way. Every write loads chan_o from bits 28:21 and rx_sel_o from bit 19 (1 = receive, 0 = transmit).
- R3: intr_o shows the head event's type code in bits 4:2 and its 8-bit vector in bits 12:5. All other bits are 0. intr_o is all zero when no event is queued. A request on ev_req_i bit k is latched at one edge, enters the queue at the next edge, and carries vector ev_chan_i. The type codes are 1 tx end-of-frame, 2 statistics overflow, 3 rx end-of-frame, 4 dummy, 5 tx end-of-channel, 6 adapter check and 7 rx end-of-channel.
- R4: At most one waiting event enters the queue per cycle, chosen in the fixed order 6, 7, 5, 4, 3, 2, 1.
- R5: Queued events leave in the order they entered.
- R6: A write with bit 29 set removes min(bits 7:0, queued count) head entries. The result is visible in the cycle after the write.
- R7: irq_o is 1 exactly when delivery is enabled and the queue is not empty. Bit 10 enables delivery and bit 11 disables it; bit 11 wins if both are set.
- R8: A write with bit 12 set raises a dummy event (type 4) whose vector is bits 28:21.
- R9: A start with bit 19 = 0 is refused when a type-5 event is waiting or queued. The check uses the state before this write, so an acknowledge in the same write does not count. The refused start gives no go_o pulse and raises an adapter-check event (type 6) whose vector is bits 28:21.
- R10: After an adapter check, no write produces go_o until reset. stop_o still works.
- R11: ev_req_i bits 0, 4 and 6 are ignored. A repeated request for a type that is waiting but not yet queued is merged and keeps the first vector. When the queue is full, waiting requests hold and are not lost.
- R12: cmd_o holds the last written command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word |
| ev_req_i | input | 8 | Event request strobes, one bit per type code |
| ev_chan_i | input | 8 | Vector attached to engine requests |
| cmd_o | output | 32 | Last written command word |
| intr_o | output | 16 | Head event type and vector |
| irq_o | output | 1 | Interrupt line |
| go_o | output | 1 | Channel start pulse |
| stop_o | output | 1 | Channel stop pulse |
| chan_o | output | 8 | Channel selected by the last write |
| rx_sel_o | output | 1 | Receive/transmit select from the last write |

## Verification
The assertions assume that all inputs are synchronous to clk_i. They also assume that cmd_wdata_i matters only in cycles where cmd_we_i is high, and that ev_chan_i matters only where some ev_req_i bit is set. The stimulus changes inputs only on the falling edge, so each input has a single value at every rising edge. Directed phases cover simultaneous requests, merging, a full queue, over-long acknowledges and the refused start. A random phase then sets arbitrary command bits, including starts, acknowledges and enable changes, at the same time as event requests. The reference model follows every cycle.

// File: rtl/hci_pkg.sv
package hci_pkg;
  localparam int unsigned NUM_TYPES = 8;
  localparam int unsigned VEC_W     = 8;

  typedef enum logic [2:0] {
    EV_INVALID  = 3'd0,
    EV_TX_EOF   = 3'd1,
    EV_STAT_OVF = 3'd2,
    EV_RX_EOF   = 3'd3,
    EV_DUMMY    = 3'd4,
    EV_TX_EOC   = 3'd5,
    EV_ADCHK    = 3'd6,
    EV_RX_EOC   = 3'd7
  } ev_type_e;

  typedef struct packed {
    ev_type_e           typ;
    logic [VEC_W-1:0]   vec;
  } ev_entry_t;

  localparam int unsigned NUM_PRIO = NUM_TYPES - 1;
  localparam ev_type_e PRIO_ORDER [NUM_PRIO] = '{
    EV_ADCHK, EV_RX_EOC, EV_TX_EOC, EV_DUMMY, EV_RX_EOF, EV_STAT_OVF, EV_TX_EOF
  };

  // command word fields
  localparam int unsigned CB_GO     = 31;
  localparam int unsigned CB_STOP   = 30;
  localparam int unsigned CB_ACK    = 29;
  localparam int unsigned CB_CH_HI  = 28;
  localparam int unsigned CB_CH_LO  = 21;
  localparam int unsigned CB_RX     = 19;
  localparam int unsigned CB_REQINT = 12;
  localparam int unsigned CB_IOFF   = 11;
  localparam int unsigned CB_ION    = 10;
  localparam int unsigned CB_CNT_HI = 7;
endpackage

// File: rtl/hci_ev_arbiter.sv
module hci_ev_arbiter
  import hci_pkg::*;
(
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_TYPES-1:0]                  set_i,
  input  logic [NUM_TYPES-1:0][VEC_W-1:0]       set_vec_i,
  input  logic                                  ready_i,
  output logic                                  grant_valid_o,
  output ev_entry_t                             grant_o,
  output logic [NUM_TYPES-1:0]                  pend_o
);
  logic [NUM_TYPES-1:0]            pend_q;
  logic [NUM_TYPES-1:0][VEC_W-1:0] vec_q;
  logic [NUM_TYPES-1:0]            grant_oh;
  ev_type_e                        gsel;
  logic                            found;

  always_comb begin
    found = 1'b0;
    gsel  = EV_INVALID;
    for (int r = 0; r < NUM_PRIO; r++) begin
      if (!found && pend_q[PRIO_ORDER[r]]) begin
        found = 1'b1;
        gsel  = PRIO_ORDER[r];
      end
    end
    grant_oh = '0;
    if (found && ready_i) grant_oh[gsel] = 1'b1;
  end

  assign grant_valid_o = |grant_oh;
  assign grant_o       = '{typ: gsel, vec: vec_q[gsel]};
  assign pend_o        = pend_q;

  for (genvar k = 0; k < NUM_TYPES; k++) begin : g_slot
    logic keep;
    assign keep = pend_q[k] & ~grant_oh[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[k] <= 1'b0;
        vec_q[k]  <= '0;
      end else begin
        pend_q[k] <= keep | set_i[k];
        if (set_i[k] && !keep) vec_q[k] <= set_vec_i[k];
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_oh)); // R4
  AST_GRANT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !set_i[grant_o.typ]) |=> !pend_q[$past(grant_o.typ)]); // R4
endmodule

// File: rtl/hci_ev_fifo.sv
module hci_ev_fifo
  import hci_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  ev_entry_t            push_data_i,
  input  logic [CW-1:0]        pop_n_i,
  output logic                 full_o,
  output logic                 empty_o,
  output logic [CW-1:0]        cnt_o,
  output ev_entry_t            head_o,
  output logic [NUM_TYPES-1:0] present_o
);
  ev_entry_t     mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (int'(cnt_q) == DEPTH);
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign head_o  = mem_q[rd_q];

  always_comb begin
    present_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_q)) present_o[mem_q[PW'((int'(rd_q) + i) % DEPTH)].typ] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= PW'((int'(rd_q) + int'(pop_n_i)) % DEPTH);
      cnt_q <= cnt_q - pop_n_i + CW'(push_i);
      if (push_i) wr_q <= PW'((int'(wr_q) + 1) % DEPTH);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R11
  AST_POP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_n_i <= cnt_q); // R6
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH); // R11
endmodule

// File: rtl/hci_unit.sv
module hci_unit
  import hci_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  input  logic [7:0]  ev_req_i,
  input  logic [7:0]  ev_chan_i,
  output logic [31:0] cmd_o,
  output logic [15:0] intr_o,
  output logic        irq_o,
  output logic        go_o,
  output logic        stop_o,
  output logic [7:0]  chan_o,
  output logic        rx_sel_o
);
  logic [31:0] wd;
  logic        go_req, viol, tx_eoc_out;
  logic        ie_q, adchk_q;
  logic [CW-1:0] ack_n;
  logic [NUM_TYPES-1:0]            set, pend, present;
  logic [NUM_TYPES-1:0][VEC_W-1:0] set_vec;
  logic        grant_valid, full, empty;
  logic [CW-1:0] cnt;
  ev_entry_t   grant, head;

  assign wd         = cmd_wdata_i;
  assign go_req     = cmd_we_i & wd[CB_GO];
  assign tx_eoc_out = pend[EV_TX_EOC] | present[EV_TX_EOC];
  assign viol       = go_req & ~wd[CB_RX] & tx_eoc_out & ~adchk_q;

  always_comb begin
    ack_n = '0;
    if (cmd_we_i && wd[CB_ACK])
      ack_n = (int'(wd[CB_CNT_HI:0]) > int'(cnt)) ? cnt : CW'(wd[CB_CNT_HI:0]);
  end

  always_comb begin
    set = ev_req_i;
    set[EV_INVALID] = 1'b0;
    set[EV_DUMMY]   = cmd_we_i & wd[CB_REQINT];
    set[EV_ADCHK]   = viol;
    for (int k = 0; k < NUM_TYPES; k++) set_vec[k] = ev_chan_i;
    set_vec[EV_DUMMY] = wd[CB_CH_HI:CB_CH_LO];
    set_vec[EV_ADCHK] = wd[CB_CH_HI:CB_CH_LO];
  end

  hci_ev_arbiter u_arb (
    .clk_i, .rst_ni,
    .set_i         (set),
    .set_vec_i     (set_vec),
    .ready_i       (~full),
    .grant_valid_o (grant_valid),
    .grant_o       (grant),
    .pend_o        (pend)
  );

  hci_ev_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i      (grant_valid),
    .push_data_i (grant),
    .pop_n_i     (ack_n),
    .full_o      (full),
    .empty_o     (empty),
    .cnt_o       (cnt),
    .head_o      (head),
    .present_o   (present)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o    <= '0;
      go_o     <= 1'b0;
      stop_o   <= 1'b0;
      chan_o   <= '0;
      rx_sel_o <= 1'b0;
      ie_q     <= 1'b0;
      adchk_q  <= 1'b0;
    end else begin
      go_o    <= go_req & ~adchk_q & ~viol;
      stop_o  <= cmd_we_i & wd[CB_STOP];
      adchk_q <= adchk_q | viol;
      if (cmd_we_i) begin
        cmd_o    <= wd;
        chan_o   <= wd[CB_CH_HI:CB_CH_LO];
        rx_sel_o <= wd[CB_RX];
        if (wd[CB_IOFF])     ie_q <= 1'b0;
        else if (wd[CB_ION]) ie_q <= 1'b1;
      end
    end
  end

  assign irq_o  = ie_q & ~empty;
  assign intr_o = empty ? 16'h0 : {3'b000, head.vec, head.typ, 2'b00};

  AST_GO_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adchk_q |=> !go_o); // R10
  AST_VIOL_NO_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> (!go_o && adchk_q)); // R9
  AST_IRQ_HAS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (intr_o[4:2] != 3'd0)); // R7
  AST_INTR_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_o[15:13] == 3'd0) && (intr_o[1:0] == 2'd0)); // R3
endmodule

// File: tb/sim_hci_unit.sv
module sim_hci_unit;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [7:0]  req = '0;
  logic [7:0]  evch = '0;
  logic [31:0] cmd_o;
  logic [15:0] intr_o;
  logic        irq_o, go_o, stop_o, rx_o;
  logic [7:0]  chan_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  hci_unit #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wd),
    .ev_req_i(req), .ev_chan_i(evch), .cmd_o(cmd_o), .intr_o(intr_o),
    .irq_o(irq_o), .go_o(go_o), .stop_o(stop_o), .chan_o(chan_o), .rx_sel_o(rx_o)
  );

  // reference model
  int        q[$];
  bit [7:0]  m_pend;
  bit [7:0]  m_pch [8];
  bit        m_ie, m_adchk, m_go, m_stop, m_rx;
  bit [7:0]  m_ch;
  bit [31:0] m_cmd;
  int        prio [7] = '{6, 7, 5, 4, 3, 2, 1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_pend = '0; m_ie = 0; m_adchk = 0; m_go = 0; m_stop = 0; m_rx = 0;
      m_ch = '0; m_cmd = '0;
      for (int k = 0; k < 8; k++) m_pch[k] = '0;
    end else begin
      automatic bit txp = m_pend[5];
      automatic int popn = 0;
      automatic int g = -1;
      automatic bit viol;
      automatic bit [7:0] s;
      foreach (q[i]) if ((q[i] >> 8) == 5) txp = 1;
      if (we && wd[29]) popn = (int'(wd[7:0]) > q.size()) ? q.size() : int'(wd[7:0]);
      if (q.size() < DEPTH)
        for (int r = 0; r < 7; r++) if (g < 0 && m_pend[prio[r]]) g = prio[r];
      repeat (popn) void'(q.pop_front());
      if (g >= 0) q.push_back(g * 256 + int'(m_pch[g]));
      viol = we && wd[31] && !wd[19] && txp && !m_adchk;
      s = req; s[0] = 0; s[4] = we && wd[12]; s[6] = viol;
      for (int k = 0; k < 8; k++) begin
        automatic bit wasp = m_pend[k] && (k != g);
        if (s[k] && !wasp) m_pch[k] = (k == 4 || k == 6) ? wd[28:21] : evch;
        m_pend[k] = wasp || s[k];
      end
      m_go = we && wd[31] && !m_adchk && !viol;
      m_stop = we && wd[30];
      if (we) begin
        m_ch = wd[28:21]; m_rx = wd[19]; m_cmd = wd;
        if (wd[11]) m_ie = 0; else if (wd[10]) m_ie = 1;
      end
      m_adchk = m_adchk || viol;
    end
  end

  task automatic chk(bit ok, string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [15:0] ei = 16'h0;
      if (q.size() > 0) ei = {3'b000, 8'(q[0] & 255), 3'(q[0] >> 8), 2'b00};
      chk(intr_o === ei, cur, "intr_o", 32'(intr_o), 32'(ei));
      chk(irq_o === (m_ie && q.size() > 0), cur, "irq_o", 32'(irq_o), 32'(m_ie && q.size() > 0));
      chk(go_o === m_go, cur, "go_o", 32'(go_o), 32'(m_go));
      chk(stop_o === m_stop, cur, "stop_o", 32'(stop_o), 32'(m_stop));
      chk(chan_o === m_ch, cur, "chan_o", 32'(chan_o), 32'(m_ch));
      chk(rx_o === m_rx, cur, "rx_sel_o", 32'(rx_o), 32'(m_rx));
      chk(cmd_o === m_cmd, "R12", "cmd_o", cmd_o, m_cmd);
    end
  end

  task automatic drive(bit w, logic [31:0] d, logic [7:0] r, logic [7:0] c);
    @(negedge clk);
    we = w; wd = d; req = r; evch = c;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 32'h0, 8'h0, 8'h0);
  endtask
  function automatic logic [31:0] cw(bit go, bit stop, bit ack, logic [7:0] ch, bit rx,
                                     bit reqint, bit off, bit on, logic [7:0] cnt);
    return {go, stop, ack, ch, 1'b0, rx, 6'b0, reqint, off, on, 2'b0, cnt};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    cur = "R1";
    chk(intr_o == 0 && irq_o == 0 && go_o == 0 && stop_o == 0, "R1", "reset outputs",
        {intr_o, 13'b0, irq_o, go_o, stop_o}, 32'h0);
    idle(1);
    cur = "R2";
    drive(1, cw(1, 0, 0, 8'h05, 1, 0, 0, 0, 0), 0, 0);
    drive(1, cw(0, 1, 0, 8'h03, 0, 0, 0, 0, 0), 0, 0);
    drive(1, cw(1, 0, 0, 8'hA7, 0, 0, 0, 0, 0), 0, 0);
    idle(2);
    cur = "R7";
    drive(1, cw(0, 0, 0, 0, 0, 0, 0, 1, 0), 0, 0);
    idle(1);
    cur = "R3";
    drive(0, 0, 8'h02, 8'h11);
    idle(3);
    chk(intr_o == {3'b0, 8'h11, 3'd1, 2'b0}, "R3", "intr tx eof", 32'(intr_o),
        32'({3'b0, 8'h11, 3'd1, 2'b0}));
    cur = "R4";
    drive(1, cw(0, 0, 0, 8'h44, 0, 1, 0, 0, 0), 8'hAE, 8'h22);
    idle(8);
    cur = "R6";
    drive(1, cw(0, 0, 1, 0, 0, 0, 0, 0, 8'd2), 0, 0);
    drive(1, cw(0, 0, 1, 0, 0, 0, 0, 0, 8'd0), 0, 0);
    idle(1);
    drive(1, cw(0, 0, 1, 0, 0, 0, 0, 0, 8'd1), 0, 0);
    drive(1, cw(0, 0, 1, 0, 0, 0, 0, 0, 8'd200), 0, 0);
    idle(2);
    chk(intr_o == 0 && irq_o == 0, "R6", "queue drained", {intr_o, 15'b0, irq_o}, 32'h0);
    cur = "R11";
    drive(0, 0, 8'h51, 8'h33);
    idle(3);
    chk(intr_o == 0, "R11", "ignored request bits", 32'(intr_o), 32'h0);
    cur = "R5";
    for (int r = 0; r < 4; r++) drive(0, 0, 8'hAE, 8'(8'h60 + r));
    idle(4);
    cur = "R11";
    for (int r = 0; r < 6; r++) drive(0, 0, 8'hAE, 8'(8'h80 + r));
    idle(3);
    for (int r = 0; r < 14; r++) drive(1, cw(0, 0, 1, 0, 0, 0, 0, 0, 8'd1), 0, 0);
    drive(1, cw(0, 0, 1, 0, 0, 0, 0, 0, 8'd255), 0, 0);
    idle(2);
    cur = "R9";
    drive(0, 0, 8'h20, 8'h09);
    idle(2);
    drive(1, cw(1, 0, 0, 8'h0C, 1, 0, 0, 0, 0), 0, 0);
    drive(1, cw(1, 0, 1, 8'h04, 0, 0, 0, 0, 8'd1), 0, 0);
    idle(3);
    chk(intr_o == {3'b0, 8'h04, 3'd6, 2'b0}, "R9", "adapter check head", 32'(intr_o),
        32'({3'b0, 8'h04, 3'd6, 2'b0}));
    cur = "R10";
    drive(1, cw(1, 0, 0, 8'h01, 1, 0, 0, 0, 0), 0, 0);
    drive(1, cw(1, 1, 1, 8'h02, 0, 0, 0, 0, 8'd5), 0, 0);
    idle(1);
    chk(go_o == 0 && stop_o == 1, "R10", "go blocked stop ok", {30'b0, go_o, stop_o}, 32'h1);
    cur = "R8";
    drive(1, cw(0, 0, 0, 8'h5A, 0, 1, 0, 0, 0), 0, 0);
    idle(3);
    chk(intr_o == {3'b0, 8'h5A, 3'd4, 2'b0}, "R8", "dummy event", 32'(intr_o),
        32'({3'b0, 8'h5A, 3'd4, 2'b0}));
    cur = "R7";
    drive(1, cw(0, 0, 0, 0, 0, 0, 1, 1, 0), 0, 0);
    idle(2);
    chk(irq_o == 0, "R7", "off wins over on", 32'(irq_o), 32'h0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cur = "R4";
    for (int i = 0; i < 3000; i++) begin
      automatic bit w = ($urandom_range(0, 3) == 0);
      automatic logic [31:0] d = $urandom;
      if ($urandom_range(0, 1) == 1) d[7:0] = 8'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) d[31] = 1'b0;
      drive(w, d, ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h0, 8'($urandom));
    end
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule